// File: doc/BRIEF.md
# Two-Channel Timer Capture Unit

This block records when events happen on two external input pins. A free-running 16-bit timer count enters the block on an input bus. When a pin shows the edge its channel is set up for, the block stores the count present at that moment in that channel's capture register. Each channel can be set to capture on rising edges, on falling edges, on both, or on none.

A processor with an 8-bit data path reaches the block through a small register interface. That interface holds the edge selection, the per-channel interrupt enables, the capture flags and the captured values, which are read one byte at a time. A read of a low byte locks that channel until its high byte is read, so the two halves always come from the same capture. Every accepted capture raises a flag. A flag that is enabled drives the interrupt request.

Top module: `tmr_capture`

## Requirements
- R1: After reset, every readable register reads 0x00 and irq_o is low.
- R2: Register offsets are: 0x0 edge control (R/W; bits 1:0 select channel A, bits 3:2 select channel B, bits 7:4 read 0), 0x1 interrupt enable (R/W; bit 0 A, bit 1 B, other bits read 0), 0x2 capture flags (bit 0 A, bit 1 B), 0x4/0x5 channel A low/high byte, 0x6/0x7 channel B low/high byte. Reading any other offset returns 0x00.
- R3: The 2-bit edge selection of a channel encodes 00 = no capture, 01 = rising edge only, 10 = falling edge only, 11 = both edges.
- R4: An edge on pin 0 (A) writes only capture pair A, and an edge on pin 1 (B) writes only capture pair B.
- R5: If a pin changes just before rising clock edge k, the captured value is the timer count present at rising edge k+2.
- R6: A read of a channel's low byte blocks all later capture events on that channel until its high byte is read. This includes an event due in the same cycle as the low-byte read. A blocked event changes neither the value nor the flag.
- R7: Locks are kept per channel, so a pending high-byte read on A does not block captures on B.
- R8: Writes to the capture byte offsets and to the flag offset have no effect.
- R9: Each accepted capture sets that channel's flag. A read of the flag register returns the flags and clears them.
- R10: A capture accepted in the same cycle as a flag-register read leaves its flag set afterwards.
- R11: irq_o is high exactly while some flag is set whose enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_cnt_i | input | 16 | Current count of the free-running timer |
| cap_pin_i | input | NUM_CH | Capture input pins, asynchronous (bit 0 = A, bit 1 = B) |
| addr_i | input | ADDR_W | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; read side effects happen at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: NUM_CH = 2 and SYNC_STAGES = 2. Two stages make the capture latency fixed, so the bench can change the timer count on each clock around an edge and check that exactly the count at the third edge is stored. Two channels make it possible to check routing, independent locks and mixed interrupt enables. Reads are placed on the exact cycle a capture fires, which covers the blocking of same-cycle events and the flag that must stay set.

// File: rtl/tcap_pkg.sv
`timescale 1ns/1ps
package tcap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int CNT_W     = 16;
  localparam int DATA_W    = 8;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_IEN   = 1;
  localparam int OFS_FLAG  = 2;
  localparam int OFS_CAP0  = 4;
endpackage

// File: rtl/tcap_edge.sv
`timescale 1ns/1ps
module tcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= lvl;
    end
  end

  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;
endmodule

// File: rtl/tcap_chan.sv
`timescale 1ns/1ps
module tcap_chan
  import tcap_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rise_i,
  input  logic      fall_i,
  input  edge_sel_e sel_i,
  input  logic [W-1:0] cnt_i,
  input  logic      rd_lo_i,
  input  logic      rd_hi_i,
  output logic [W-1:0] cap_o,
  output logic      lock_o,
  output logic      fire_o
);
  logic hit;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit = rise_i;
      EDGE_FALL: hit = fall_i;
      EDGE_BOTH: hit = rise_i | fall_i;
      default:   hit = 1'b0;
    endcase
  end

  // high-byte read at this edge already returned the held value, so a new event may land
  assign fire_o = hit && !rd_lo_i && (!lock_o || rd_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o  <= '0;
      lock_o <= 1'b0;
    end else begin
      if (fire_o) cap_o <= cnt_i;
      if (rd_lo_i)      lock_o <= 1'b1;
      else if (rd_hi_i) lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture
  import tcap_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    tmr_cnt_i,
  input  logic [NUM_CH-1:0]   cap_pin_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int CTRL_W = 2 * NUM_CH;

  logic [CTRL_W-1:0]              ctrl_q;
  logic [NUM_CH-1:0]              ien_q, flag_q;
  logic [NUM_CH-1:0]              fire, lock_q, rise, fall, rd_lo, rd_hi;
  logic [NUM_CH-1:0][CNT_W-1:0]   cap_q;
  logic                           rd_flag;
  logic                           unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign rd_flag = rd_en_i && (addr_i == ADDR_W'(OFS_FLAG));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(OFS_CAP0 + 2 * c);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(OFS_CAP0 + 2 * c + 1);

    assign rd_lo[c] = rd_en_i && (addr_i == LO);
    assign rd_hi[c] = rd_en_i && (addr_i == HI);

    tcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_pin_i[c]),
      .rise_o (rise[c]),
      .fall_o (fall[c])
    );

    tcap_chan #(.W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise[c]),
      .fall_i  (fall[c]),
      .sel_i   (edge_sel_e'(ctrl_q[2*c +: 2])),
      .cnt_i   (tmr_cnt_i),
      .rd_lo_i (rd_lo[c]),
      .rd_hi_i (rd_hi[c]),
      .cap_o   (cap_q[c]),
      .lock_o  (lock_q[c]),
      .fire_o  (fire[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_W'(OFS_CTRL)) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_en_i && addr_i == ADDR_W'(OFS_IEN))  ien_q  <= wdata_i[NUM_CH-1:0];
      // set wins over read-clear
      flag_q <= (flag_q & ~{NUM_CH{rd_flag}}) | fire;
    end
  end

  assign irq_o = |(flag_q & ien_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) rdata_o = DATA_W'(ctrl_q);
    if (addr_i == ADDR_W'(OFS_IEN))  rdata_o = DATA_W'(ien_q);
    if (addr_i == ADDR_W'(OFS_FLAG)) rdata_o = DATA_W'(flag_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(OFS_CAP0 + 2 * c))     rdata_o = cap_q[c][7:0];
      if (addr_i == ADDR_W'(OFS_CAP0 + 2 * c + 1)) rdata_o = cap_q[c][15:8];
    end
  end
endmodule

// File: rtl/tcap_checker.sv
`timescale 1ns/1ps
module tcap_checker
  import tcap_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rd_en_i,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [NUM_CH-1:0]             flag_q,
  input logic [NUM_CH-1:0]             ien_q,
  input logic [NUM_CH-1:0]             lock_q,
  input logic [NUM_CH-1:0]             fire,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cap_q,
  input logic                          irq_o
);
  logic rd_flag;
  assign rd_flag = rd_en_i && (addr_i == ADDR_W'(OFS_FLAG));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(OFS_CAP0 + 2 * c + 1);

    p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q[c] && !(rd_en_i && addr_i == HI)) |=> $stable(cap_q[c]));

    p_flag_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_flag && !fire[c]) |=> !flag_q[c]);

    p_flag_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire[c] |=> flag_q[c]);
  end

  p_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire == '0) |=> $stable(cap_q));

  p_irq_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(fire & ien_q)) && !wr_en_i) |=> irq_o);
endmodule

bind tmr_capture tcap_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_en_i (rd_en_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .flag_q  (flag_q),
  .ien_q   (ien_q),
  .lock_q  (lock_q),
  .fire    (fire),
  .cap_q   (cap_q),
  .irq_o   (irq_o)
);

// File: tb/tmr_capture_bench.sv
`timescale 1ns/1ps
module tmr_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr = '0;
  logic [1:0]  pin = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr_capture u_tmr_capture (
    .clk_i(clk), .rst_ni(rst_n), .tmr_cnt_i(tmr), .cap_pin_i(pin),
    .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr8(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd8(logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd16(int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(4'(4 + 2 * ch), lo);
    rd8(4'(5 + 2 * ch), hi);
    v = {hi, lo};
  endtask

  task automatic edge_at(int ch, logic lvl, logic [15:0] cnt);
    tmr = cnt; pin[ch] = lvl;
    tick(4);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd8(4'(a), d);
      chk("R1 reg", 16'(d), 16'h0);
    end
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    wr8(4'h0, 8'hFD);
    rd8(4'h0, d); chk("R2 ctrl readback", 16'(d), 16'h0D);
    wr8(4'h1, 8'hFF);
    rd8(4'h1, d); chk("R2 ien readback", 16'(d), 16'h03);
    rd8(4'h9, d); chk("R2 unmapped", 16'(d), 16'h0);
    wr8(4'h1, 8'h00);
    wr8(4'h0, 8'h00);
  endtask

  task automatic t_modes;
    logic [15:0] v;
    logic [7:0]  d;
    wr8(4'h0, 8'h01);                 // A rising
    edge_at(0, 1'b1, 16'h1234);
    rd16(0, v); chk("R3 rise captures", v, 16'h1234);
    rd16(1, v); chk("R4 B untouched", v, 16'h0);
    edge_at(0, 1'b0, 16'h2222);
    rd16(0, v); chk("R3 rise ignores fall", v, 16'h1234);
    wr8(4'h0, 8'h02);                 // A falling
    edge_at(0, 1'b1, 16'h3333);
    rd16(0, v); chk("R3 fall ignores rise", v, 16'h1234);
    edge_at(0, 1'b0, 16'h4444);
    rd16(0, v); chk("R3 fall captures", v, 16'h4444);
    wr8(4'h0, 8'h03);                 // A both
    edge_at(0, 1'b1, 16'h5555);
    rd16(0, v); chk("R3 both rise", v, 16'h5555);
    edge_at(0, 1'b0, 16'h6666);
    rd16(0, v); chk("R3 both fall", v, 16'h6666);
    wr8(4'h0, 8'h00);                 // A off
    edge_at(0, 1'b1, 16'h7777);
    rd16(0, v); chk("R3 off", v, 16'h6666);
    edge_at(0, 1'b0, 16'h7778);
    wr8(4'h0, 8'h04);                 // B rising
    edge_at(1, 1'b1, 16'hBEEF);
    rd16(1, v); chk("R4 B pair", v, 16'hBEEF);
    rd16(0, v); chk("R4 A untouched", v, 16'h6666);
    edge_at(1, 1'b0, 16'h0);
    rd8(4'h2, d);
  endtask

  task automatic t_latency;
    logic [15:0] v;
    wr8(4'h0, 8'h01);
    tmr = 16'h0100; pin[0] = 1'b1;
    @(negedge clk); tmr = 16'h0101;
    @(negedge clk); tmr = 16'h0102;
    @(negedge clk); tmr = 16'h0103;
    tick(2);
    rd16(0, v); chk("R5 third edge", v, 16'h0102);
    edge_at(0, 1'b0, 16'h0);
  endtask

  task automatic t_lock;
    logic [15:0] v;
    logic [7:0]  d;
    wr8(4'h0, 8'h01);
    edge_at(0, 1'b1, 16'h1111);
    edge_at(0, 1'b0, 16'h0);
    rd8(4'h2, d);
    rd8(4'h4, d); chk("R6 low byte", 16'(d), 16'h11);
    edge_at(0, 1'b1, 16'h2222);
    rd8(4'h2, d); chk("R6 blocked no flag", 16'(d), 16'h0);
    rd8(4'h5, d); chk("R6 high coherent", 16'(d), 16'h11);
    edge_at(0, 1'b0, 16'h0);
    edge_at(0, 1'b1, 16'h3333);
    rd16(0, v); chk("R6 unlocked", v, 16'h3333);
    edge_at(0, 1'b0, 16'h0);
    rd8(4'h2, d);
    // low read lands on the capture cycle
    tmr = 16'h4444; pin[0] = 1'b1;
    tick(2);
    rd8(4'h4, d); chk("R6 same-cycle low", 16'(d), 16'h33);
    rd8(4'h5, d); chk("R6 same-cycle high", 16'(d), 16'h33);
    rd8(4'h2, d); chk("R6 same-cycle no flag", 16'(d), 16'h0);
    edge_at(0, 1'b0, 16'h0);
  endtask

  task automatic t_per_ch;
    logic [15:0] v;
    logic [7:0]  d;
    wr8(4'h0, 8'h05);
    rd8(4'h4, d);                     // lock A
    edge_at(1, 1'b1, 16'h5A5A);
    rd16(1, v); chk("R7 B free while A locked", v, 16'h5A5A);
    rd8(4'h5, d);
    edge_at(1, 1'b0, 16'h0);
    rd8(4'h2, d);
  endtask

  task automatic t_ro;
    logic [15:0] v;
    logic [7:0]  d;
    wr8(4'h0, 8'h01);
    edge_at(0, 1'b1, 16'hC0DE);
    for (int a = 4; a < 8; a++) wr8(4'(a), 8'hFF);
    wr8(4'h2, 8'h00);
    rd16(0, v); chk("R8 cap A", v, 16'hC0DE);
    rd16(1, v); chk("R8 cap B", v, 16'h5A5A);
    rd8(4'h2, d); chk("R8 flag kept", 16'(d), 16'h01);
    edge_at(0, 1'b0, 16'h0);
  endtask

  task automatic t_flags;
    logic [7:0] d;
    wr8(4'h0, 8'h05);
    wr8(4'h1, 8'h00);
    edge_at(0, 1'b1, 16'h0AAA);
    chk("R11 disabled", 16'(irq), 16'h0);
    wr8(4'h1, 8'h01);
    #1 chk("R11 enabled", 16'(irq), 16'h1);
    rd8(4'h2, d); chk("R9 flag read", 16'(d), 16'h01);
    rd8(4'h2, d); chk("R9 flag cleared", 16'(d), 16'h00);
    chk("R11 cleared", 16'(irq), 16'h0);
    tmr = 16'h0BBB; pin[1] = 1'b1;
    tick(2);
    rd8(4'h2, d); chk("R10 read before set", 16'(d), 16'h00);
    #1 chk("R11 B not enabled", 16'(irq), 16'h0);
    rd8(4'h2, d); chk("R10 flag survives", 16'(d), 16'h02);
    edge_at(1, 1'b0, 16'h0);
    edge_at(1, 1'b1, 16'h0CCC);
    wr8(4'h1, 8'h02);
    #1 chk("R11 B enabled", 16'(irq), 16'h1);
    rd8(4'h2, d);
    edge_at(1, 1'b0, 16'h0);
    edge_at(0, 1'b0, 16'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_regmap();
    t_modes();
    t_latency();
    t_lock();
    t_per_ch();
    t_ro();
    t_flags();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule